// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Memory

This block is the read side of a one-time-programmable serial memory that holds a configuration bitstream. A host clocks it, and it presents one stored bit per rising edge on a serial output. An internal bit address counter selects that bit. Two controls gate the counter. The first is an active-low chip enable. The second is one pin that acts as both reset and output enable, and a parameter sets which level of that pin means reset. The three-state data pin is modelled as a data value plus an output-enable flag.

When the counter moves past the highest address, a sticky terminal flag is set. From then on the counter stops, this device stops driving data, and its chip-enable-out goes low. That output feeds the chip enable of the next device, so a chain of devices reads out as one unbroken stream. Only a reset clears the flag.

The bit array is plain storage. A simple write port fills it before any read.

Top module: `cfgmem_serial`

## Requirements
- R1: With `ce_n` low and the reset/enable pin at its enable level, each rising clock moves the counter up by one. `data_o` shows the bit at the current address without waiting for a clock, so the first bit is valid before the first edge.
- R2: While the reset/enable pin is at its reset level, the counter returns to zero and the terminal flag clears on the next edge. In the same state, `data_oe` is low and `ce_out_n` is high.
- R3: `RST_ACTIVE_HIGH`=1 makes a high `rst_oe` mean reset and a low one mean enable. `RST_ACTIVE_HIGH`=0 reverses both levels.
- R4: `data_oe` is low whenever `ce_n` is high or reset is active. `data_o` is 0 whenever `data_oe` is low.
- R5: While `ce_n` is high (standby) and reset is inactive, the counter and the terminal flag keep their values.
- R6: Once the terminal flag is set, further clocks do not change the counter. Only reset clears the flag.
- R7: The clock that reads past address `DEPTH`-1 sets the terminal flag. After that clock, `data_oe` is low and `ce_out_n` is low, so the next device takes over with no gap. Data output and a low `ce_out_n` are never asserted together.
- R8: While the terminal flag is set and reset is inactive, `ce_out_n` equals `ce_n`.
- R9: When `wr_en` is high on a rising clock, `wr_bit` is stored at `wr_addr`.
- R10: `DEPTH` sets the number of stored bits, and the terminal count is `DEPTH`-1. The full device is `DEPTH`=1048576. The default is small for elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial read clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the state flops |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output enable; polarity set by `RST_ACTIVE_HIGH` |
| wr_en | input | 1 | Array write strobe for preload |
| wr_addr | input | AW | Array write bit address |
| wr_bit | input | 1 | Bit value to store |
| data_o | output | 1 | Serial data value (0 when not driven) |
| data_oe | output | 1 | Serial data drive enable |
| ce_out_n | output | 1 | Chip enable for the next device in a chain, active low |

## Verification
The bench builds two instances and chains them. The first has `DEPTH`=16 with active-high reset. The second has `DEPTH`=12 with active-low reset, and its reset pin is driven with the inverted signal. This puts both polarities and a depth that is not a power of two on the same clock. Because the devices are small, a full read across the handoff, the exhausted-chain state and many random terminal-count events all happen within a few hundred cycles. Random mixes of standby and reset are checked against a bench model of both counters.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  typedef struct packed {
    logic rst_act;
    logic oe_act;
    logic ce_act;
  } cfgmem_ctl_t;

  function automatic int addr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/cfgmem_ctl_decode.sv
module cfgmem_ctl_decode
  import cfgmem_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic        rst_oe,
  input  logic        ce_n,
  output cfgmem_ctl_t ctl
);

  logic rst_lvl;

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_hi
      assign rst_lvl = rst_oe;
    end else begin : g_rst_lo
      assign rst_lvl = ~rst_oe;
    end
  endgenerate

  assign ctl.rst_act = rst_lvl;
  assign ctl.oe_act  = ~rst_lvl;
  assign ctl.ce_act  = ~ce_n;

endmodule

// File: rtl/cfgmem_addr_seq.sv
module cfgmem_addr_seq
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = addr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfgmem_ctl_t   ctl,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          end_q, end_d;
  logic          step;
  logic          upd;

  assign step = ctl.ce_act & ctl.oe_act & ~end_q;
  assign upd  = ctl.rst_act | step;

  always_comb begin
    addr_d = addr_q;
    end_d  = end_q;
    if (ctl.rst_act) begin
      addr_d = '0;
      end_d  = 1'b0;
    end else if (step) begin
      if (addr_q == LAST) begin
        end_d = 1'b1;
      end else begin
        addr_d = addr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      end_q  <= 1'b0;
    end else if (upd) begin
      addr_q <= addr_d;
      end_q  <= end_d;
    end
  end

  assign addr   = addr_q;
  assign at_end = end_q;

endmodule

// File: rtl/cfgmem_bit_array.sv
module cfgmem_bit_array
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = addr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);

  logic [DEPTH-1:0] cells;
  logic             wr_ok;

  assign wr_ok = wr_en & (int'(wr_addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      cells[wr_addr] <= wr_bit;
    end
  end

  assign rd_bit = (int'(rd_addr) < DEPTH) ? cells[rd_addr] : 1'b0;

endmodule

// File: rtl/cfgmem_out_stage.sv
module cfgmem_out_stage
  import cfgmem_pkg::*;
(
  input  cfgmem_ctl_t ctl,
  input  logic        at_end,
  input  logic        rd_bit,
  output logic        data_o,
  output logic        data_oe,
  output logic        ce_out_n
);

  logic live;

  assign live     = ctl.ce_act & ctl.oe_act;
  assign data_oe  = live & ~at_end;
  assign data_o   = data_oe & rd_bit;
  assign ce_out_n = ~(live & at_end);

endmodule

// File: rtl/cfgmem_serial.sv
module cfgmem_serial
  import cfgmem_pkg::*;
#(
  parameter int  DEPTH           = 2048,
  parameter bit  RST_ACTIVE_HIGH = 1'b1,
  localparam int AW              = addr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          data_o,
  output logic          data_oe,
  output logic          ce_out_n
);

  cfgmem_ctl_t   ctl;
  logic [AW-1:0] cur_addr;
  logic          past_tc;
  logic          rd_bit;

  cfgmem_ctl_decode #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_dec (
    .rst_oe (rst_oe),
    .ce_n   (ce_n),
    .ctl    (ctl)
  );

  cfgmem_addr_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .addr   (cur_addr),
    .at_end (past_tc)
  );

  cfgmem_bit_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .rd_addr (cur_addr),
    .rd_bit  (rd_bit)
  );

  cfgmem_out_stage u_out (
    .ctl      (ctl),
    .at_end   (past_tc),
    .rd_bit   (rd_bit),
    .data_o   (data_o),
    .data_oe  (data_oe),
    .ce_out_n (ce_out_n)
  );

endmodule

// File: rtl/cfgmem_serial_chk.sv
module cfgmem_serial_chk
  import cfgmem_pkg::*;
#(
  parameter int  DEPTH           = 2048,
  parameter bit  RST_ACTIVE_HIGH = 1'b1,
  localparam int AW              = addr_w(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          rst_oe,
  input logic          data_o,
  input logic          data_oe,
  input logic          ce_out_n,
  input logic [AW-1:0] cur_addr,
  input logic          past_tc
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic rst_act;
  assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (cur_addr == '0 && !past_tc)); // R2
  AST_RESET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |-> (!data_oe && ce_out_n)); // R2
  AST_DISABLED_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || rst_act) |-> !data_oe); // R4
  AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> !data_o); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !rst_act && !past_tc && cur_addr != LAST) |=>
      (cur_addr == AW'($past(cur_addr) + 1'b1))); // R1
  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !rst_act) |=> ($stable(cur_addr) && $stable(past_tc))); // R5
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (past_tc && !rst_act) |=> (past_tc && $stable(cur_addr))); // R6
  AST_LAST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !rst_act && !past_tc && cur_addr == LAST) |=> past_tc); // R7
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_oe && !ce_out_n)); // R7
  AST_CEO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_tc && !rst_act) |-> (ce_out_n == ce_n)); // R8

endmodule

bind cfgmem_serial cfgmem_serial_chk #(
  .DEPTH(DEPTH), .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .rst_oe   (rst_oe),
  .data_o   (data_o),
  .data_oe  (data_oe),
  .ce_out_n (ce_out_n),
  .cur_addr (cur_addr),
  .past_tc  (past_tc)
);

// File: tb/cfgmem_serial_tb.sv
`timescale 1ns/1ps
module cfgmem_serial_tb;

  localparam int D0 = 16;
  localparam int D1 = 12;

  logic clk, rst_n, rs, ce_n;
  logic wr_en0, wr_en1, wr_bit;
  logic [3:0] wr_addr;
  logic d0, oe0, ceo0, d1, oe1, ceo1;
  logic rs_pin1, bus;

  int checks = 0;
  int failures = 0;

  bit img0 [D0];
  bit img1 [D1];
  int m_a0, m_a1;
  bit m_t0, m_t1;

  assign rs_pin1 = ~rs;
  assign bus = oe0 ? d0 : (oe1 ? d1 : 1'b1);

  cfgmem_serial #(.DEPTH(D0), .RST_ACTIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(rs),
    .wr_en(wr_en0), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .data_o(d0), .data_oe(oe0), .ce_out_n(ceo0));

  cfgmem_serial #(.DEPTH(D1), .RST_ACTIVE_HIGH(1'b0)) u_nxt (
    .clk(clk), .rst_n(rst_n), .ce_n(ceo0), .rst_oe(rs_pin1),
    .wr_en(wr_en1), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .data_o(d1), .data_oe(oe1), .ce_out_n(ceo1));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit e_oe0();  return !ce_n && !rs && !m_t0; endfunction
  function automatic bit e_ceo0(); return rs || ce_n || !m_t0; endfunction
  function automatic bit e_oe1();  return !e_ceo0() && !rs && !m_t1; endfunction
  function automatic bit e_ceo1(); return rs || e_ceo0() || !m_t1; endfunction
  function automatic bit e_bus();
    if (e_oe0()) return img0[m_a0];
    if (e_oe1()) return img1[m_a1];
    return 1'b1;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_all();
    chk(oe0, e_oe0(), "R4 first data_oe");
    chk(oe1, e_oe1(), "R4 second data_oe");
    chk(oe0 ? 1'b0 : d0, 1'b0, "R4 first idle data level");
    chk(ceo0, e_ceo0(), "R8 first ce_out_n");
    chk(ceo1, e_ceo1(), "R8 second ce_out_n");
    chk(bus, e_bus(), "R1 serial bit on chain");
  endtask

  task automatic tick();
    bit adv0, adv1;
    int na0, na1;
    bit nt0, nt1;
    adv0 = !rs && !ce_n && !m_t0;
    adv1 = !rs && !e_ceo0() && !m_t1;
    na0 = m_a0; nt0 = m_t0; na1 = m_a1; nt1 = m_t1;
    if (rs) begin
      na0 = 0; nt0 = 0; na1 = 0; nt1 = 0;
    end else begin
      if (adv0) begin if (m_a0 == D0-1) nt0 = 1; else na0 = m_a0 + 1; end
      if (adv1) begin if (m_a1 == D1-1) nt1 = 1; else na1 = m_a1 + 1; end
    end
    if (wr_en0) img0[wr_addr] = wr_bit;
    if (wr_en1 && wr_addr < D1) img1[wr_addr] = wr_bit;
    @(posedge clk);
    #2;
    m_a0 = na0; m_t0 = nt0; m_a1 = na1; m_t1 = nt1;
    chk_all();
  endtask

  task automatic wr(input bit second, input int a, input bit b);
    wr_addr = 4'(a); wr_bit = b;
    wr_en0 = !second; wr_en1 = second;
    tick();
    wr_en0 = 1'b0; wr_en1 = 1'b0;
  endtask

  initial begin
    #(20 * 50000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic rec [D0+D1];
    bit tmp;
    int v;
    rst_n = 1'b0; rs = 1'b1; ce_n = 1'b1;
    wr_en0 = 1'b0; wr_en1 = 1'b0; wr_addr = '0; wr_bit = 1'b0;
    m_a0 = 0; m_a1 = 0; m_t0 = 0; m_t1 = 0;
    v = int'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(oe0, 1'b0, "R2 reset holds data off");
    chk(ceo0, 1'b1, "R2 reset holds ce_out_n high");
    chk(oe1, 1'b0, "R3 inverted-polarity device in reset");
    chk(ceo1, 1'b1, "R3 inverted-polarity ce_out_n high");

    for (int i = 0; i < D0; i++) wr(1'b0, i, 1'($urandom));
    for (int i = 0; i < D1; i++) wr(1'b1, i, 1'($urandom));

    // R9: overwrite bit 0 and see the new value on the first read
    tmp = !img0[0];
    wr(1'b0, 0, tmp);
    rs = 1'b0; ce_n = 1'b0;
    #1;
    chk(bus, tmp, "R9 write port value at address 0");
    chk(bus, img0[0], "R1 first bit valid before first clock");

    // full stream across the handoff
    rec[0] = bus;
    for (int k = 1; k < D0 + D1; k++) begin
      tick();
      rec[k] = bus;
      if (k == D0-1) chk(oe0, 1'b1, "R10 first device drives its last bit");
      if (k == D0)   chk(oe0, 1'b0, "R10 first device stops after DEPTH bits");
      if (k == D0)   chk(ceo0, 1'b0, "R7 ce_out_n low after last bit");
    end
    for (int k = 0; k < D0 + D1; k++)
      chk(rec[k], (k < D0) ? img0[k] : img1[k-D0], "R7 continuous chained bitstream");

    repeat (5) tick();
    chk(oe0, 1'b0, "R6 first device stays finished");
    chk(oe1, 1'b0, "R6 second device stays finished");
    chk(ceo1, 1'b0, "R6 chain end ce_out_n low");

    ce_n = 1'b1; #1;
    chk(ceo0, 1'b1, "R8 ce_out_n follows ce_n high");
    tick();
    ce_n = 1'b0; #1;
    chk(ceo0, 1'b0, "R8 ce_out_n follows ce_n low");
    chk(oe0, 1'b0, "R6 no restart without reset");

    // reset restart and standby hold
    rs = 1'b1; tick();
    rs = 1'b0; #1;
    chk(bus, img0[0], "R2 reset returns to address 0");
    repeat (3) tick();
    ce_n = 1'b1;
    repeat (4) tick();
    ce_n = 1'b0; #1;
    chk(bus, img0[3], "R5 standby leaves address unchanged");
    chk(oe0, 1'b1, "R5 device resumes after standby");

    // random mix
    for (int k = 0; k < 400; k++) begin
      rs   = ($urandom % 25) == 0;
      ce_n = ($urandom % 5) == 0;
      #1;
      chk_all();
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule